// File: doc/BRIEF.md
# Multicast Chain Splitting Stage

This stage sits at one node of a three-dimensional mesh and carries out multicast as a sequence of ordinary unicasts. A header arrives as one to three 32-bit flits. It holds a destination count and a list of node coordinates sorted in dimension order. If the node's own address is first in the list, the stage flags local delivery and removes that entry.

It then divides the remaining list by repeated halving. The upper half goes out as a new unicast header, addressed to the first node of that half and carrying the whole half. The lower half stays with the node, and the halving repeats until nothing is left. Every node that receives a header repeats the same procedure, so after the first step the originating node takes no further part in forwarding.

For each emitted header the stage also computes the output port, resolving x first, then y, then z. Emitted headers wait at the output until the downstream side accepts them. The unicast router datapath does not change. Each emitted header uses the same layout as an incoming header.

Top module: `mcast_split_stage`

## Requirements
- R1: A header is received as flits taken on cycles where `in_valid` and `in_ready` are both high. Flit k fills header bits [32k+31:32k]. Bits [3:0] hold the destination count n. Entry i sits at bits [4+6i+5:4+6i] and packs x in bits [5:4], y in [3:2] and z in [1:0]. The header takes ceil((4+6n)/32) flits, and `in_ready` is high while the stage is idle.
- R2: If n is non-zero and entry 0 equals `node_addr`, then `local_hit` is high for exactly one cycle, the cycle after the last flit is taken. That entry is then dropped from the list to be split.
- R3: With m entries remaining, the stage emits a header with count ceil(m/2) that carries entries floor(m/2) through m-1 in order, with all unused bits zero. m then becomes floor(m/2), and this repeats until m is 0. The first header appears the second cycle after the last flit is taken.
- R4: The first entry of every emitted header is the address of the node it is sent to.
- R5: `out_port` gives the dimension-ordered direction from `node_addr` to the emitted header's first entry. The first coordinate that differs, taken in the order x, y, z, decides the port. A larger target coordinate gives the plus direction and a smaller one the minus direction. Encoding: local 0, +X 1, -X 2, +Y 3, -Y 4, +Z 5, -Z 6.
- R6: While `out_valid` is high and `out_ready` is low, `out_hdr` and `out_port` hold their values.
- R7: `in_ready` is low from the cycle after the last flit is taken until the last emitted header is accepted. No flit is taken during that time.
- R8: During and after reset, `out_valid` and `local_hit` are low and `in_ready` is high. A reset in the middle of emission drops the pending headers.
- R9: A header with count 0 causes no emission and no local hit.
- R10: If entry 0 differs from `node_addr`, there is no local hit and all n entries are split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_addr | input | 6 | This node's {x,y,z} address |
| in_valid | input | 1 | Incoming header flit present |
| in_flit | input | 32 | Incoming header flit |
| in_ready | output | 1 | Stage accepts a flit |
| out_valid | output | 1 | Emitted unicast header present |
| out_ready | input | 1 | Downstream accepts the emitted header |
| out_hdr | output | 96 | Emitted header, same layout as the input |
| out_port | output | 3 | Output direction for the emitted header |
| local_hit | output | 1 | One-cycle local delivery flag |

## Verification
The assertions assume well-formed headers. The listed entries must be strictly increasing as 6-bit values, which makes them lexicographic in x, then y, then z. The node address must not appear anywhere in the list except possibly at its head. Given those two conditions, no emitted header is ever routed to the local port.

The bench builds every destination list as an arithmetic run with a positive stride and no wraparound. This keeps each list sorted and free of duplicates. Where the node's address sits inside a list, it is always at the head.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int COORD_W = 2;
  localparam int ADDR_W  = 3 * COORD_W;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_XP    = 3'd1,
    PORT_XN    = 3'd2,
    PORT_YP    = 3'd3,
    PORT_YN    = 3'd4,
    PORT_ZP    = 3'd5,
    PORT_ZN    = 3'd6
  } port_e;

  // Dimension-ordered direction: x first, then y, then z.
  function automatic port_e dor_port(input logic [ADDR_W-1:0] here,
                                     input logic [ADDR_W-1:0] dest);
    logic [COORD_W-1:0] hx, hy, hz, dx, dy, dz;
    hx = here[3*COORD_W-1:2*COORD_W];
    hy = here[2*COORD_W-1:COORD_W];
    hz = here[COORD_W-1:0];
    dx = dest[3*COORD_W-1:2*COORD_W];
    dy = dest[2*COORD_W-1:COORD_W];
    dz = dest[COORD_W-1:0];
    if (dx > hx)      return PORT_XP;
    else if (dx < hx) return PORT_XN;
    else if (dy > hy) return PORT_YP;
    else if (dy < hy) return PORT_YN;
    else if (dz > hz) return PORT_ZP;
    else if (dz < hz) return PORT_ZN;
    else              return PORT_LOCAL;
  endfunction
endpackage

// File: rtl/mcs_hdr_collect.sv
module mcs_hdr_collect
  import mcs_pkg::*;
#(
  parameter int FLIT_W   = 32,
  parameter int MAX_DEST = 15,
  localparam int CNT_W    = $clog2(MAX_DEST + 1),
  localparam int HDR_BITS = CNT_W + MAX_DEST * ADDR_W,
  localparam int NFLIT    = (HDR_BITS + FLIT_W - 1) / FLIT_W,
  localparam int BUF_W    = NFLIT * FLIT_W,
  localparam int FIDX_W   = (NFLIT > 1) ? $clog2(NFLIT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [FLIT_W-1:0] in_flit,
  output logic              in_ready,
  input  logic              sink_busy,
  output logic              hdr_vld,
  output logic [BUF_W-1:0]  hdr_buf
);
  logic [FIDX_W:0] fidx_q;
  logic [FIDX_W:0] need_q;
  logic [FIDX_W:0] need_now;
  logic            take;
  logic            last_flit;
  logic            hdr_vld_q;
  logic [BUF_W-1:0] hbuf_q;

  // Flits needed for a header that lists c destinations.
  function automatic logic [FIDX_W:0] flits_for(input logic [CNT_W-1:0] c);
    int bits;
    bits = CNT_W + int'(c) * ADDR_W;
    return (FIDX_W+1)'((bits + FLIT_W - 1) / FLIT_W);
  endfunction

  assign in_ready  = !hdr_vld_q && !sink_busy;
  assign take      = in_valid && in_ready;
  assign need_now  = (fidx_q == '0) ? flits_for(in_flit[CNT_W-1:0]) : need_q;
  assign last_flit = take && ((fidx_q + 1'b1) == need_now);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fidx_q    <= '0;
      need_q    <= '0;
      hdr_vld_q <= 1'b0;
      hbuf_q    <= '0;
    end else begin
      hdr_vld_q <= last_flit;
      if (take) begin
        if (fidx_q == '0) begin
          hbuf_q <= {{(BUF_W-FLIT_W){1'b0}}, in_flit};
          need_q <= need_now;
        end else begin
          hbuf_q[int'(fidx_q)*FLIT_W +: FLIT_W] <= in_flit;
        end
        fidx_q <= last_flit ? '0 : fidx_q + 1'b1;
      end
    end
  end

  assign hdr_vld = hdr_vld_q;
  assign hdr_buf = hbuf_q;

  // Ordering flags between neighbouring entries, brought out for the check.
  logic [CNT_W-1:0]   rx_cnt;
  logic [MAX_DEST-1:0] ord_ok;
  assign rx_cnt = hbuf_q[CNT_W-1:0];
  assign ord_ok[MAX_DEST-1] = 1'b1;
  for (genvar i = 0; i < MAX_DEST - 1; i++) begin : g_ord
    assign ord_ok[i] = (i + 1 >= int'(rx_cnt)) ||
      (hbuf_q[CNT_W + i*ADDR_W +: ADDR_W] < hbuf_q[CNT_W + (i+1)*ADDR_W +: ADDR_W]);
  end

  // R1: a completed header lists its entries in strictly increasing order
  a_r1_ordered_list: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_vld |-> (&ord_ok));
endmodule

// File: rtl/mcs_chain_split.sv
module mcs_chain_split
  import mcs_pkg::*;
#(
  parameter int FLIT_W   = 32,
  parameter int MAX_DEST = 15,
  localparam int CNT_W    = $clog2(MAX_DEST + 1),
  localparam int HDR_BITS = CNT_W + MAX_DEST * ADDR_W,
  localparam int NFLIT    = (HDR_BITS + FLIT_W - 1) / FLIT_W,
  localparam int BUF_W    = NFLIT * FLIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] node_addr,
  input  logic              hdr_vld,
  input  logic [BUF_W-1:0]  hdr_buf,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BUF_W-1:0]  out_hdr,
  output logic [ADDR_W-1:0] out_dest,
  output logic              busy,
  output logic              local_hit
);
  logic [ADDR_W-1:0] ent_in [MAX_DEST];
  logic [ADDR_W-1:0] list_q [MAX_DEST];
  logic [CNT_W-1:0]  cnt_in;
  logic [CNT_W-1:0]  rem_q;
  logic [CNT_W-1:0]  keep_cnt;
  logic [CNT_W-1:0]  send_cnt;
  logic              head_hit;
  logic              emit_fire;

  assign cnt_in = hdr_buf[CNT_W-1:0];
  for (genvar i = 0; i < MAX_DEST; i++) begin : g_unpack
    assign ent_in[i] = hdr_buf[CNT_W + i*ADDR_W +: ADDR_W];
  end
  if (BUF_W > HDR_BITS) begin : g_pad
    logic unused_pad;
    assign unused_pad = ^hdr_buf[BUF_W-1:HDR_BITS];
  end

  assign head_hit  = (cnt_in != '0) && (ent_in[0] == node_addr);
  assign local_hit = hdr_vld && head_hit;

  // Halving split: the lower half stays, the upper half is sent.
  assign keep_cnt  = rem_q >> 1;
  assign send_cnt  = rem_q - keep_cnt;
  assign busy      = (rem_q != '0);
  assign out_valid = busy;
  assign emit_fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      for (int i = 0; i < MAX_DEST; i++) list_q[i] <= '0;
    end else if (hdr_vld) begin
      rem_q <= cnt_in - CNT_W'(head_hit);
      for (int i = 0; i < MAX_DEST; i++) begin
        if (!head_hit)          list_q[i] <= ent_in[i];
        else if (i + 1 < MAX_DEST) list_q[i] <= ent_in[i+1];
        else                    list_q[i] <= '0;
      end
    end else if (emit_fire) begin
      rem_q <= keep_cnt;
    end
  end

  always_comb begin
    out_hdr = '0;
    out_hdr[CNT_W-1:0] = send_cnt;
    for (int i = 0; i < MAX_DEST; i++) begin
      if (i < int'(send_cnt) && (int'(keep_cnt) + i) < MAX_DEST)
        out_hdr[CNT_W + i*ADDR_W +: ADDR_W] = list_q[int'(keep_cnt) + i];
    end
  end

  always_comb begin
    out_dest = '0;
    for (int i = 0; i < MAX_DEST; i++)
      if (i == int'(keep_cnt)) out_dest = list_q[i];
  end

  // R2: local delivery flag lasts one cycle
  a_r2_hit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    local_hit |=> !local_hit);
  // R3: each emitted subset is no larger than the one before
  a_r3_shrink: assert property (@(posedge clk) disable iff (!rst_n)
    emit_fire |=> (!out_valid || send_cnt <= $past(send_cnt)));
  // R4: the routed destination is the first entry of the emitted header
  a_r4_dest_is_head: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_dest == out_hdr[CNT_W +: ADDR_W]));
  // R6: a stalled header holds
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hdr)));
  // R7: no new header while splitting
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_vld |-> !busy);
endmodule

// File: rtl/mcs_route.sv
module mcs_route
  import mcs_pkg::*;
(
  input  logic [ADDR_W-1:0] here,
  input  logic [ADDR_W-1:0] dest,
  output port_e             port
);
  assign port = dor_port(here, dest);
endmodule

// File: rtl/mcast_split_stage.sv
module mcast_split_stage
  import mcs_pkg::*;
#(
  parameter int FLIT_W   = 32,
  parameter int MAX_DEST = 15,
  localparam int CNT_W    = $clog2(MAX_DEST + 1),
  localparam int HDR_BITS = CNT_W + MAX_DEST * ADDR_W,
  localparam int NFLIT    = (HDR_BITS + FLIT_W - 1) / FLIT_W,
  localparam int BUF_W    = NFLIT * FLIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] node_addr,
  input  logic              in_valid,
  input  logic [FLIT_W-1:0] in_flit,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BUF_W-1:0]  out_hdr,
  output logic [2:0]        out_port,
  output logic              local_hit
);
  logic              hdr_vld;
  logic [BUF_W-1:0]  hdr_buf;
  logic              split_busy;
  logic [ADDR_W-1:0] out_dest;
  port_e             route_port;

  mcs_hdr_collect #(.FLIT_W(FLIT_W), .MAX_DEST(MAX_DEST)) u_collect (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_flit   (in_flit),
    .in_ready  (in_ready),
    .sink_busy (split_busy),
    .hdr_vld   (hdr_vld),
    .hdr_buf   (hdr_buf)
  );

  mcs_chain_split #(.FLIT_W(FLIT_W), .MAX_DEST(MAX_DEST)) u_split (
    .clk       (clk),
    .rst_n     (rst_n),
    .node_addr (node_addr),
    .hdr_vld   (hdr_vld),
    .hdr_buf   (hdr_buf),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_hdr   (out_hdr),
    .out_dest  (out_dest),
    .busy      (split_busy),
    .local_hit (local_hit)
  );

  mcs_route u_route (
    .here (node_addr),
    .dest (out_dest),
    .port (route_port)
  );

  assign out_port = route_port;

  // R5: a well-formed list never routes an emitted header back to this node
  a_r5_never_local: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_port != 3'd0));
  // R7: the input is closed while headers are pending
  a_r7_closed_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    split_busy |-> !in_ready);
  // R6: the port holds while stalled
  a_r6_port_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_port));
endmodule

// File: tb/mcast_split_stage_tb.sv
`timescale 1ns/1ps
module mcast_split_stage_tb;
  localparam int NV = 8;
  localparam int V_SELF   [NV] = '{5, 0, 42, 63, 20, 0, 10, 34};
  localparam int V_CNT    [NV] = '{9, 15, 1, 0, 5, 2, 11, 4};
  localparam int V_START  [NV] = '{5, 1, 42, 0, 20, 62, 10, 1};
  localparam int V_STRIDE [NV] = '{3, 4, 1, 0, 10, 1, 5, 16};
  localparam int V_STALL  [NV] = '{0, 1, 0, 0, 1, 0, 1, 0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  node_addr = '0;
  logic        in_valid = 1'b0;
  logic [31:0] in_flit = '0;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [95:0] out_hdr;
  logic [2:0]  out_port;
  logic        local_hit;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mcast_split_stage u_dut (
    .clk(clk), .rst_n(rst_n), .node_addr(node_addr),
    .in_valid(in_valid), .in_flit(in_flit), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_hdr(out_hdr),
    .out_port(out_port), .local_hit(local_hit)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [95:0] act, input logic [95:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Direction by comparing coordinates one dimension at a time.
  function automatic int want_port(input int h, input int d);
    int hc[3];
    int dc[3];
    for (int k = 0; k < 3; k++) begin
      hc[k] = (h >> (4 - 2*k)) & 3;
      dc[k] = (d >> (4 - 2*k)) & 3;
    end
    for (int k = 0; k < 3; k++)
      if (dc[k] != hc[k]) return 1 + 2*k + ((dc[k] < hc[k]) ? 1 : 0);
    return 0;
  endfunction

  task automatic run_vec(input int self_a, input int n, input int start,
                         input int stride, input bit stall);
    int ent[16];
    int lst[16];
    int m;
    int nexp;
    int nfl;
    int k;
    int waitc;
    int guard;
    bit hit;
    logic [95:0] hb;
    logic [95:0] eh[16];
    int ep[16];

    hb = '0;
    hb[3:0] = 4'(n);
    for (int i = 0; i < n; i++) begin
      ent[i] = start + i*stride;
      hb[4 + 6*i +: 6] = 6'(ent[i]);
    end
    nfl = (4 + 6*n + 31) / 32;
    hit = (n > 0) && (ent[0] == self_a);
    m = 0;
    for (int i = (hit ? 1 : 0); i < n; i++) begin
      lst[m] = ent[i];
      m++;
    end
    nexp = 0;
    while (m > 0) begin
      int lo;
      lo = m / 2;
      eh[nexp] = '0;
      eh[nexp][3:0] = 4'(m - lo);
      for (int j = lo; j < m; j++) eh[nexp][4 + 6*(j-lo) +: 6] = 6'(lst[j]);
      ep[nexp] = want_port(self_a, lst[lo]);
      nexp++;
      m = lo;
    end

    @(negedge clk);
    node_addr = 6'(self_a);
    for (int f = 0; f < nfl; f++) begin
      chk(in_ready == 1'b1, "R1", "in_ready before flit", 96'(in_ready), 96'd1);
      in_valid = 1'b1;
      in_flit  = hb[32*f +: 32];
      @(negedge clk);
    end
    // One cycle after the last flit: local flag, input closed.
    in_valid = 1'b1;
    in_flit  = 32'hFFFF_FFFF;
    chk(local_hit == hit, hit ? "R2" : (n == 0 ? "R9" : "R10"), "local_hit",
        96'(local_hit), 96'(hit));
    chk(in_ready == 1'b0, "R1 R7", "in_ready after last flit", 96'(in_ready), 96'd0);
    k = 0;
    waitc = 0;
    guard = 0;
    @(negedge clk);
    while (out_valid && guard < 400) begin
      guard++;
      chk(local_hit == 1'b0, "R2", "local_hit pulse width", 96'(local_hit), 96'd0);
      chk(in_ready == 1'b0, "R7", "in_ready while emitting", 96'(in_ready), 96'd0);
      if (k < nexp) begin
        chk(out_hdr == eh[k], (waitc > 0) ? "R6" : "R3", "emitted header", out_hdr, eh[k]);
        chk(out_hdr[9:4] == eh[k][9:4], "R4", "header head entry",
            96'(out_hdr[9:4]), 96'(eh[k][9:4]));
        chk(int'(out_port) == ep[k], (waitc > 0) ? "R6" : "R5", "out_port",
            96'(out_port), 96'(ep[k]));
      end else begin
        chk(1'b0, "R3", "extra emission", out_hdr, '0);
      end
      out_ready = !(stall && waitc < 2);
      if (out_ready) begin
        k++;
        waitc = 0;
      end else begin
        waitc++;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    chk(k == nexp, (n == 0) ? "R9" : "R3", "emission count", 96'(k), 96'(nexp));
    chk(in_ready == 1'b1, "R7", "in_ready after emission", 96'(in_ready), 96'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8", "out_valid in reset", 96'(out_valid), 96'd0);
    chk(in_ready == 1'b1, "R8", "in_ready in reset", 96'(in_ready), 96'd1);
    chk(local_hit == 1'b0, "R8", "local_hit in reset", 96'(local_hit), 96'd0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++)
      run_vec(V_SELF[v], V_CNT[v], V_START[v], V_STRIDE[v], V_STALL[v] != 0);

    // Directed: reset in the middle of an emission sequence (R8).
    @(negedge clk);
    node_addr = 6'd0;
    out_ready = 1'b0;
    in_valid = 1'b1;
    in_flit = {2'b0, 6'd21, 6'd17, 6'd13, 6'd9, 4'd4};
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b1, "R6", "stalled header pending", 96'(out_valid), 96'd1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8", "out_valid after mid reset", 96'(out_valid), 96'd0);
    chk(in_ready == 1'b1, "R8", "in_ready after mid reset", 96'(in_ready), 96'd1);
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8", "nothing pending after reset", 96'(out_valid), 96'd0);

    // Directed: largest list from an outside node, with stalls.
    run_vec(63, 15, 0, 4, 1'b1);
    // Directed: single destination that is not this node (R10).
    run_vec(0, 1, 63, 1, 1'b0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule